// File: doc/BRIEF.md
# Radio Packet Framer

This block turns one transmit request into a serial bit stream ready for a modulator. A single start strobe captures the destination address, the address-width code, whether the frame carries a length/identity control field, the 2-bit packet identity, the no-acknowledge flag, the payload length and the checksum options. The framer then walks through a fixed sequence of fields: a one-byte alternating training pattern, the address, the optional 9-bit control field, the payload and the checksum.

Timing is set entirely by the bit-enable input: each strobe releases at most one bit. Payload bytes are pulled one at a time through a ready/valid handshake, only when the payload field needs them. A strobe that arrives while no payload byte is held is dropped, which stalls the stream instead of sending a gap. A `done` pulse marks the final bit. After that the framer is idle and accepts the next start.

Top module: `rfFramer`

## Requirements
- R1: The frame opens with 8 training bits: 1,0,1,0,1,0,1,0 when the first transmitted address bit is 1, and 0,1,0,1,0,1,0,1 when it is 0.
- R2: The address-width code selects the address field length: 2'b10 gives 4 bytes and 2'b11 gives 5 bytes. Both 2'b01 and the illegal code 2'b00 give 3 bytes. Only the low-order bytes of `addrIn` are used, sent from the highest used bit down to bit 0.
- R3: When `dynLenEn` is 1, a 9-bit control field follows the address: the 6-bit payload length MSB first, then the 2-bit identity MSB first, then the no-acknowledge flag. When `dynLenEn` is 0 the field is absent.
- R4: Payload bytes are taken through `byteReady`/`byteValid` and sent unmodified, each MSB first, in order of arrival. A length above 32 is treated as 32, and this clamped value is also the one written into the control field. A length of 0 yields no payload field and no handshake.
- R5: With `crcEn`=1 and `crcWide`=0, an 8-bit checksum ends the frame. It is the MSB-first polynomial division by x^8+x^2+x+1 (0x07), preset to 0xFF, over the address, control and payload bits only, and is sent MSB first.
- R6: With `crcEn`=1 and `crcWide`=1, the checksum is 16 bits: polynomial x^16+x^12+x^5+1 (0x1021), preset to 0xFFFF, over the same bits, sent MSB first.
- R7: With `crcEn`=0 no checksum is appended; the frame ends with its last payload, control or address bit.
- R8: Every `bitValid` pulse follows a `bitEn` strobe by exactly one cycle and carries one frame bit on `bitOut`. A strobe that comes while `byteReady` is high produces no bit.
- R9: `done` is high for one cycle, together with the last bit's `bitValid`. A `start` while `busy` is high is ignored, and configuration inputs are only sampled on the accepted start.
- R10: After reset, `busy`, `bitValid`, `byteReady` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (accepted only when idle) |
| addrIn | input | 40 | Destination address, low bytes used |
| widthCode | input | 2 | Address-width code |
| dynLenEn | input | 1 | Insert the 9-bit control field |
| pidIn | input | 2 | Packet identity for the control field |
| noAckIn | input | 1 | No-acknowledge flag for the control field |
| lenIn | input | 6 | Payload length in bytes |
| crcEn | input | 1 | Append a checksum |
| crcWide | input | 1 | 1: 16-bit checksum, 0: 8-bit |
| bitEn | input | 1 | Bit-time strobe |
| byteData | input | 8 | Payload byte |
| byteValid | input | 1 | Payload byte offered |
| byteReady | output | 1 | Framer wants a payload byte |
| bitOut | output | 1 | Serial frame bit |
| bitValid | output | 1 | `bitOut` carries a new bit this cycle |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Final bit of the frame |

## Verification
The bound assertions watch the timing rules on every cycle: a bit never appears without a strobe one cycle earlier or outside a frame, a pending byte request is held until it is met, and `done` coincides with the last bit and is followed by a silent cycle. The content of the stream can only be judged by the bench. This covers the training-pattern choice, the width decoding, the control-field layout, the length clamp and both checksums. The bench compares each received frame bit by bit against a frame it builds itself, under random strobe densities, random byte stalls and a stray start issued mid-frame.

// File: rtl/rfFramerPkg.sv
package rfFramerPkg;
  localparam int ADDR_BYTES_MAX = 5;
  localparam int ADDR_W = ADDR_BYTES_MAX * 8;
  localparam int AIDX_W = $clog2(ADDR_W);
  localparam int PAY_MAX = 32;
  localparam int LEN_W = 6;
  localparam int CNT_W = $clog2(PAY_MAX * 8 + 1);
  localparam int PRE_BITS = 8;
  localparam int CTRL_BITS = LEN_W + 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_ADDR,
    PH_CTRL,
    PH_PAY,
    PH_CRC
  } phaseT;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             emit;
    phaseT            phase;
    logic [CNT_W-1:0] cnt;
  } strobeT;

  // field sizes and byte status from datapath to control
  typedef struct packed {
    logic             byteHeld;
    logic             dynOn;
    logic             crcOn;
    logic [CNT_W-1:0] addrBits;
    logic [CNT_W-1:0] payBits;
    logic [CNT_W-1:0] crcBits;
  } pathStatT;
endpackage

// File: rtl/rfFramerCtrl.sv
module rfFramerCtrl
  import rfFramerPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     bitEn,
  input  pathStatT stat,
  output strobeT   strb,
  output logic     busy,
  output logic     done,
  output logic     byteReady
);
  phaseT phase, nextPhase, afterAddr, afterCtrl, afterPay;
  logic [CNT_W-1:0] cnt, phaseLen;
  logic canEmit, lastBit;

  always_comb begin
    afterPay  = stat.crcOn ? PH_CRC : PH_IDLE;
    afterCtrl = (stat.payBits != '0) ? PH_PAY : afterPay;
    afterAddr = stat.dynOn ? PH_CTRL : afterCtrl;
    unique case (phase)
      PH_PRE:  begin phaseLen = CNT_W'(PRE_BITS);  nextPhase = PH_ADDR;   end
      PH_ADDR: begin phaseLen = stat.addrBits;     nextPhase = afterAddr; end
      PH_CTRL: begin phaseLen = CNT_W'(CTRL_BITS); nextPhase = afterCtrl; end
      PH_PAY:  begin phaseLen = stat.payBits;      nextPhase = afterPay;  end
      PH_CRC:  begin phaseLen = stat.crcBits;      nextPhase = PH_IDLE;   end
      default: begin phaseLen = '0;                nextPhase = PH_IDLE;   end
    endcase
    lastBit = (cnt == phaseLen - 1'b1);
    canEmit = bitEn && (phase != PH_IDLE) && ((phase != PH_PAY) || stat.byteHeld);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= canEmit && lastBit && (nextPhase == PH_IDLE);
      if (phase == PH_IDLE) begin
        cnt <= '0;
        if (start) phase <= PH_PRE;
      end else if (canEmit) begin
        if (lastBit) begin
          phase <= nextPhase;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign busy       = (phase != PH_IDLE);
  assign byteReady  = (phase == PH_PAY) && !stat.byteHeld;
  assign strb.load  = start && (phase == PH_IDLE);
  assign strb.emit  = canEmit;
  assign strb.phase = phase;
  assign strb.cnt   = cnt;
endmodule

// File: rtl/rfFramerPath.sv
module rfFramerPath
  import rfFramerPkg::*;
#(
  parameter logic [7:0]  CRC8_POLY  = 8'h07,
  parameter logic [7:0]  CRC8_INIT  = 8'hFF,
  parameter logic [15:0] CRC16_POLY = 16'h1021,
  parameter logic [15:0] CRC16_INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [1:0]        widthCode,
  input  logic              dynIn,
  input  logic [1:0]        pidIn,
  input  logic              noAckIn,
  input  logic [LEN_W-1:0]  lenIn,
  input  logic              crcEnIn,
  input  logic              crcWideIn,
  input  logic [7:0]        byteData,
  input  logic              byteValid,
  input  logic              byteReady,
  output pathStatT          stat,
  output logic              bitOut,
  output logic              bitValid
);
  logic [ADDR_W-1:0]    addrR;
  logic [CNT_W-1:0]     addrBitsR, widthBits;
  logic                 dynR, noAckR, crcOnR, crcWideR, byteHeld;
  logic [1:0]           pidR;
  logic [LEN_W-1:0]     lenR, lenClamped;
  logic [15:0]          crcR;
  logic [7:0]           payByte, preByte;
  logic [CTRL_BITS-1:0] ctrlWord;
  logic [CNT_W-1:0]     addrTop, addrIdx;
  logic [3:0]           ctrlIdx, crcIdx;
  logic [2:0]           byteIdx;
  logic                 firstBit, curBit, feedCrc;

  // one MSB-first division step; narrow checksum lives in the low byte
  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic b, input logic wide);
    logic [7:0] n8;
    if (wide) begin
      crcStep = {c[14:0], 1'b0} ^ ((c[15] ^ b) ? CRC16_POLY : 16'h0000);
    end else begin
      n8 = {c[6:0], 1'b0} ^ ((c[7] ^ b) ? CRC8_POLY : 8'h00);
      crcStep = {8'h00, n8};
    end
  endfunction

  always_comb begin
    unique case (widthCode)
      2'b10:   widthBits = CNT_W'(32);
      2'b11:   widthBits = CNT_W'(40);
      default: widthBits = CNT_W'(24);
    endcase
    lenClamped = (lenIn > LEN_W'(PAY_MAX)) ? LEN_W'(PAY_MAX) : lenIn;
  end

  always_comb begin
    addrTop  = addrBitsR - 1'b1;
    addrIdx  = addrTop - strb.cnt;
    firstBit = addrR[addrTop[AIDX_W-1:0]];
    preByte  = firstBit ? 8'hAA : 8'h55;
    ctrlWord = {lenR, pidR, noAckR};
    ctrlIdx  = 4'(CTRL_BITS - 1) - strb.cnt[3:0];
    crcIdx   = (crcWideR ? 4'd15 : 4'd7) - strb.cnt[3:0];
    byteIdx  = 3'd7 - strb.cnt[2:0];
    unique case (strb.phase)
      PH_PRE:  curBit = preByte[byteIdx];
      PH_ADDR: curBit = addrR[addrIdx[AIDX_W-1:0]];
      PH_CTRL: curBit = ctrlWord[ctrlIdx];
      PH_PAY:  curBit = payByte[byteIdx];
      PH_CRC:  curBit = crcR[crcIdx];
      default: curBit = 1'b0;
    endcase
    feedCrc = strb.emit && ((strb.phase == PH_ADDR) || (strb.phase == PH_CTRL) ||
                            (strb.phase == PH_PAY));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrR     <= '0;
      addrBitsR <= CNT_W'(24);
      dynR      <= 1'b0;
      pidR      <= '0;
      noAckR    <= 1'b0;
      lenR      <= '0;
      crcOnR    <= 1'b0;
      crcWideR  <= 1'b0;
      crcR      <= '0;
    end else if (strb.load) begin
      addrR     <= addrIn;
      addrBitsR <= widthBits;
      dynR      <= dynIn;
      pidR      <= pidIn;
      noAckR    <= noAckIn;
      lenR      <= lenClamped;
      crcOnR    <= crcEnIn;
      crcWideR  <= crcWideIn;
      crcR      <= crcWideIn ? CRC16_INIT : {8'h00, CRC8_INIT};
    end else if (feedCrc) begin
      crcR <= crcStep(crcR, curBit, crcWideR);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      payByte  <= '0;
      byteHeld <= 1'b0;
    end else if (strb.load) begin
      byteHeld <= 1'b0;
    end else if (byteValid && byteReady) begin
      payByte  <= byteData;
      byteHeld <= 1'b1;
    end else if (strb.emit && (strb.phase == PH_PAY) && (strb.cnt[2:0] == 3'd7)) begin
      byteHeld <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitOut   <= 1'b0;
      bitValid <= 1'b0;
    end else begin
      bitValid <= strb.emit;
      if (strb.emit) bitOut <= curBit;
    end
  end

  assign stat.byteHeld = byteHeld;
  assign stat.dynOn    = dynR;
  assign stat.crcOn    = crcOnR;
  assign stat.addrBits = addrBitsR;
  assign stat.payBits  = CNT_W'({lenR, 3'b000});
  assign stat.crcBits  = crcOnR ? (crcWideR ? CNT_W'(16) : CNT_W'(8)) : '0;
endmodule

// File: rtl/rfFramer.sv
module rfFramer
  import rfFramerPkg::*;
#(
  parameter logic [7:0]  CRC8_POLY  = 8'h07,
  parameter logic [7:0]  CRC8_INIT  = 8'hFF,
  parameter logic [15:0] CRC16_POLY = 16'h1021,
  parameter logic [15:0] CRC16_INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [1:0]        widthCode,
  input  logic              dynLenEn,
  input  logic [1:0]        pidIn,
  input  logic              noAckIn,
  input  logic [LEN_W-1:0]  lenIn,
  input  logic              crcEn,
  input  logic              crcWide,
  input  logic              bitEn,
  input  logic [7:0]        byteData,
  input  logic              byteValid,
  output logic              byteReady,
  output logic              bitOut,
  output logic              bitValid,
  output logic              busy,
  output logic              done
);
  strobeT   strb;
  pathStatT stat;

  rfFramerCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .bitEn(bitEn), .stat(stat),
    .strb(strb), .busy(busy), .done(done), .byteReady(byteReady)
  );

  rfFramerPath #(
    .CRC8_POLY(CRC8_POLY), .CRC8_INIT(CRC8_INIT),
    .CRC16_POLY(CRC16_POLY), .CRC16_INIT(CRC16_INIT)
  ) path_i (
    .clk(clk), .rstN(rstN), .strb(strb), .addrIn(addrIn), .widthCode(widthCode),
    .dynIn(dynLenEn), .pidIn(pidIn), .noAckIn(noAckIn), .lenIn(lenIn),
    .crcEnIn(crcEn), .crcWideIn(crcWide), .byteData(byteData),
    .byteValid(byteValid), .byteReady(byteReady), .stat(stat),
    .bitOut(bitOut), .bitValid(bitValid)
  );
endmodule

// File: rtl/rfFramerChecker.sv
module rfFramerChecker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic bitEn,
  input logic byteValid,
  input logic byteReady,
  input logic bitValid,
  input logic busy,
  input logic done
);
  a_r8_bit_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> $past(bitEn));

  a_r8_bit_inside_frame: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> $past(busy));

  a_r4_ready_held: assert property (@(posedge clk) disable iff (!rstN)
    (byteReady && !byteValid) |=> byteReady);

  a_r4_ready_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> busy);

  a_r9_done_with_last_bit: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (bitValid && !busy));

  a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !bitValid);

  a_r9_frame_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
endmodule

bind rfFramer rfFramerChecker chk_i (
  .clk(clk), .rstN(rstN), .start(start), .bitEn(bitEn), .byteValid(byteValid),
  .byteReady(byteReady), .bitValid(bitValid), .busy(busy), .done(done)
);

// File: tb/rfFramer_tb_top.sv
module rfFramer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_LIMIT = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, dynLenEn = 1'b0, noAckIn = 1'b0, crcEn = 1'b0, crcWide = 1'b0;
  logic bitEn = 1'b0, byteValid = 1'b0;
  logic [39:0] addrIn = '0;
  logic [1:0] widthCode = '0, pidIn = '0;
  logic [5:0] lenIn = '0;
  logic [7:0] byteData = '0;
  logic byteReady, bitOut, bitValid, busy, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  rfFramer dut_i (
    .clk(clk), .rstN(rstN), .start(start), .addrIn(addrIn), .widthCode(widthCode),
    .dynLenEn(dynLenEn), .pidIn(pidIn), .noAckIn(noAckIn), .lenIn(lenIn),
    .crcEn(crcEn), .crcWide(crcWide), .bitEn(bitEn), .byteData(byteData),
    .byteValid(byteValid), .byteReady(byteReady), .bitOut(bitOut),
    .bitValid(bitValid), .busy(busy), .done(done)
  );

  int checks = 0, fails = 0;
  logic [39:0] cfgAddr;
  logic [1:0] cfgCode, cfgPid;
  logic cfgDyn, cfgNoAck, cfgCrc, cfgWide;
  logic [5:0] cfgLen;
  logic [7:0] payMem [0:63];
  bit expBits [0:511];
  bit gotBits [0:511];
  int addrS, ctrlS, payS, crcS, endS, gotLen;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic buildExpected();
    int nA, effLen, k;
    logic [7:0] pre;
    logic [15:0] c;
    logic fb;
    nA = (cfgCode == 2'b10) ? 4 : (cfgCode == 2'b11) ? 5 : 3;
    effLen = (cfgLen > 6'd32) ? 32 : int'(cfgLen);
    k = 0;
    pre = cfgAddr[nA*8-1] ? 8'hAA : 8'h55;
    for (int i = 7; i >= 0; i--) begin expBits[k] = pre[i]; k++; end
    addrS = k;
    for (int i = nA*8-1; i >= 0; i--) begin expBits[k] = cfgAddr[i]; k++; end
    ctrlS = k;
    if (cfgDyn) begin
      for (int i = 5; i >= 0; i--) begin expBits[k] = effLen[i]; k++; end
      expBits[k] = cfgPid[1]; k++;
      expBits[k] = cfgPid[0]; k++;
      expBits[k] = cfgNoAck; k++;
    end
    payS = k;
    for (int b = 0; b < effLen; b++)
      for (int i = 7; i >= 0; i--) begin expBits[k] = payMem[b][i]; k++; end
    crcS = k;
    if (cfgCrc) begin
      c = cfgWide ? 16'hFFFF : 16'h00FF;
      for (int j = addrS; j < crcS; j++) begin
        if (cfgWide) begin
          fb = c[15] ^ expBits[j];
          c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end else begin
          fb = c[7] ^ expBits[j];
          c = {8'h00, c[6:0], 1'b0} ^ (fb ? 16'h0007 : 16'h0000);
        end
      end
      for (int i = (cfgWide ? 15 : 7); i >= 0; i--) begin expBits[k] = c[i]; k++; end
    end
    endS = k;
  endtask

  task automatic cmpSeg(input string req, input int s, input int e);
    int bad = 0;
    for (int i = s; i < e; i++) if (gotBits[i] != expBits[i]) bad++;
    check(bad == 0 && gotLen >= e, req, bad, 0);
  endtask

  task automatic runFrame(input int pct, input bit midStart);
    int idx = 0, cyc = 0, stray = 0, stallBad = 0;
    bit prevEn = 0, prevStall = 0, doneSeen = 0, doneOk = 0;
    for (int i = 0; i < 64; i++) payMem[i] = 8'($urandom);
    buildExpected();
    gotLen = 0;
    @(negedge clk);
    addrIn = cfgAddr; widthCode = cfgCode; dynLenEn = cfgDyn; pidIn = cfgPid;
    noAckIn = cfgNoAck; lenIn = cfgLen; crcEn = cfgCrc; crcWide = cfgWide;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // disturb configuration after acceptance (R9)
    addrIn = ~cfgAddr; widthCode = ~cfgCode; dynLenEn = ~cfgDyn; lenIn = cfgLen ^ 6'd5;
    crcWide = ~cfgWide; pidIn = ~cfgPid;
    while (!doneSeen && cyc < FRAME_LIMIT) begin
      if (bitValid) begin
        if (gotLen < 512) gotBits[gotLen] = bitOut;
        gotLen++;
        if (!prevEn) stray++;
      end
      if (prevStall && bitValid) stallBad++;
      if (done) begin doneSeen = 1; doneOk = bitValid; end
      bitEn = (($urandom % 100) < pct);
      byteValid = (($urandom % 100) < 70);
      byteData = payMem[idx];
      if (byteValid && byteReady) idx++;
      prevStall = bitEn && byteReady;
      prevEn = bitEn;
      start = midStart && (cyc == 40);
      cyc++;
      @(negedge clk);
    end
    bitEn = 1'b0; byteValid = 1'b0; start = 1'b0;
    check(doneSeen, "R9 frame finished", doneSeen, 1);
    check(doneOk, "R9 done with last bit", doneOk, 1);
    cmpSeg("R1 training pattern", 0, addrS);
    cmpSeg("R2 address", addrS, ctrlS);
    if (cfgDyn) cmpSeg("R3 control field", ctrlS, payS);
    else check(gotLen == endS, "R3 no control field length", gotLen, endS);
    cmpSeg("R4 payload", payS, crcS);
    check(idx == (payS == crcS ? 0 : (crcS - payS) / 8), "R4 bytes taken", idx, (crcS - payS) / 8);
    if (!cfgCrc) check(gotLen == crcS, "R7 no checksum", gotLen, crcS);
    else if (cfgWide) cmpSeg("R6 16-bit checksum", crcS, endS);
    else cmpSeg("R5 8-bit checksum", crcS, endS);
    check(gotLen == endS, "R8 bit count", gotLen, endS);
    check(stray == 0, "R8 bit without strobe", stray, 0);
    check(stallBad == 0, "R8 stalled strobe emitted", stallBad, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic setCfg(input logic [39:0] a, input logic [1:0] code, input logic dyn,
                        input logic [1:0] pid, input logic na, input logic [5:0] len,
                        input logic ce, input logic cw);
    cfgAddr = a; cfgCode = code; cfgDyn = dyn; cfgPid = pid; cfgNoAck = na;
    cfgLen = len; cfgCrc = ce; cfgWide = cw;
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(20240611);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !bitValid && !byteReady && !done, "R10 reset state",
          {busy, bitValid, byteReady, done}, 0);
    // directed corners
    setCfg(40'h80_1234_5678, 2'b11, 1'b0, 2'b00, 1'b0, 6'd4, 1'b1, 1'b1);
    runFrame(100, 1'b0);
    setCfg(40'hFF_FF_12_34_56, 2'b01, 1'b1, 2'b10, 1'b1, 6'd0, 1'b1, 1'b0);
    runFrame(50, 1'b1);
    setCfg(40'h00_00_C2_C2_C2, 2'b00, 1'b1, 2'b01, 1'b0, 6'd40, 1'b0, 1'b0);
    runFrame(60, 1'b0);
    setCfg(40'hAB_7E_E7_E7_E7, 2'b10, 1'b0, 2'b11, 1'b1, 6'd33, 1'b1, 1'b0);
    runFrame(30, 1'b1);
    setCfg(40'h12_34_56_78_9A, 2'b10, 1'b1, 2'b01, 1'b1, 6'd1, 1'b1, 1'b1);
    runFrame(80, 1'b0);
    // random frames
    for (int f = 0; f < 16; f++) begin
      setCfg({8'($urandom), 32'($urandom)}, 2'($urandom), 1'($urandom), 2'($urandom),
             1'($urandom), 6'($urandom % 41), 1'($urandom), 1'($urandom));
      runFrame(30 + int'($urandom % 71), 1'($urandom));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule